// File: doc/BRIEF.md
# SHA-256 Iterative Compression Unit

This block computes a single SHA-256 compression. It takes a 256-bit chaining value and a 512-bit message block and returns the 256-bit compressed result. The datapath evaluates one round per clock. A 16-word sliding window generates the message schedule in place, and the 64 round constants are held as fixed logic. Padding, chaining across blocks and any host-side protocol are the caller's responsibility.

A caller presents `chain_in` and `block_in` and pulses `start`. The unit captures both operands and runs 64 round cycles. It then spends one extra cycle adding the captured chaining value back into the working words, and pulses `done` with the result on `digest`. Keeping that final addition in its own cycle keeps it off the path through the last round.

The controller has three states. IDLE accepts `start` (transition LAUNCH, to ROUND). ROUND runs one round per cycle, and after the last round it takes transition ROUNDS_DONE to FEED. FEED performs the feed-forward addition, raises `done` and returns to IDLE (transition FINISH).

Top module: `sha256_compress_unit`

## Requirements
- R1: During and directly after reset, `busy` and `done` are low and `digest` is all zeros.
- R2: A `start` sampled high in IDLE is accepted. `done` is then high exactly 65 rising edges after the accepting edge: 64 round cycles plus one feed-forward cycle.
- R3: `digest` equals the SHA-256 compression of `chain_in` and `block_in`, both taken as big-endian 32-bit words. Block word 0 is bits [511:480], and chaining word A is bits [255:224]. The "abc" block hashed from the standard initial value gives ba7816bf...f20015ad.
- R4: Message words 16 to 63 follow W[t] = sigma1(W[t-2]) + W[t-7] + sigma0(W[t-15]) + W[t-16], modulo 2^32. They are produced by a 16-word shifting window.
- R5: Each output word is the working word after round 63 plus the matching captured chaining word, modulo 2^32. These additions happen in a dedicated cycle after round 63.
- R6: A `start` pulse while the unit is busy has no effect, including during the feed-forward cycle. Operand inputs are not sampled after the accepting edge.
- R7: `done` is high for exactly one cycle per job. `digest` changes only in the cycle in which `done` is high and holds its value otherwise.
- R8: `busy` is high from the cycle after an accepted `start` until the result is ready, and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a compression when idle |
| chain_in | input | 256 | Chaining value, word A in the top bits |
| block_in | input | 512 | Message block, word 0 in the top bits |
| busy | output | 1 | A compression is in progress |
| done | output | 1 | One-cycle pulse: `digest` is valid |
| digest | output | 256 | Compression result, word A in the top bits |

## Verification
The bench builds the unit with the package's fixed SHA-256 sizes: 32-bit words, 64 rounds and a 16-word window. It therefore exercises the full round count, and every schedule word from index 16 to 63 feeds a checked result. Nonzero random chaining values put the feed-forward additions and their carries into view. A second `start` is injected at random points, up to and including the feed-forward cycle, to check that the 65-cycle latency and the result are unaffected.

// File: rtl/sha_pkg.sv
package sha_pkg;
    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 8;
    localparam int N_ROUNDS = 64;
    localparam int WIN      = 16;
    localparam int RND_W    = $clog2(N_ROUNDS);
    localparam int STATE_W  = WORD_W * N_WORDS;
    localparam int BLOCK_W  = WORD_W * WIN;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ROUND = 2'd1,
        S_FEED  = 2'd2
    } ctl_state_e;

    localparam logic [N_ROUNDS*WORD_W-1:0] KTAB = {
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t round_const(input logic [RND_W-1:0] idx);
        return KTAB[(N_ROUNDS - 1 - int'(idx)) * WORD_W +: WORD_W];
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t f_choose(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t f_major(input word_t a, input word_t b, input word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction
endpackage

// File: rtl/sha_msg_window.sv
module sha_msg_window
    import sha_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [BLOCK_W-1:0] block_in,
    output word_t              w_cur
);
    word_t win [WIN];
    word_t w_next;

    // Next schedule word from the window, relative to the word in slot 0.
    always_comb begin
        w_next = sml_sig1(win[WIN-2]) + win[WIN-7] + sml_sig0(win[1]) + win[0];
    end

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win[i] <= '0;
            end else if (load) begin
                win[i] <= block_in[BLOCK_W-1-WORD_W*i -: WORD_W];
            end else if (shift) begin
                if (i == WIN - 1) begin
                    win[i] <= w_next;
                end else begin
                    win[i] <= win[i+1];
                end
            end
        end
    end

    assign w_cur = win[0];

    // R4: after a load the first word presented is block word 0
    a_r4_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (w_cur == $past(block_in[BLOCK_W-1 -: WORD_W])));

    // R4: a shift moves slot 1 into the front
    a_r4_slide: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (w_cur == $past(win[1])));
endmodule

// File: rtl/sha_round_path.sv
module sha_round_path
    import sha_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               feed,
    input  logic [STATE_W-1:0] chain_in,
    input  word_t              k_cur,
    input  word_t              w_cur,
    output logic [STATE_W-1:0] digest
);
    word_t wk   [N_WORDS];
    word_t init [N_WORDS];
    word_t t1, t2;

    always_comb begin
        t1 = wk[7] + big_sig1(wk[4]) + f_choose(wk[4], wk[5], wk[6]) + k_cur + w_cur;
        t2 = big_sig0(wk[0]) + f_major(wk[0], wk[1], wk[2]);
    end

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wk[i]   <= '0;
                init[i] <= '0;
            end else if (load) begin
                wk[i]   <= chain_in[STATE_W-1-WORD_W*i -: WORD_W];
                init[i] <= chain_in[STATE_W-1-WORD_W*i -: WORD_W];
            end else if (step) begin
                if (i == 0) begin
                    wk[i] <= t1 + t2;
                end else if (i == 4) begin
                    wk[i] <= wk[3] + t1;
                end else begin
                    wk[i] <= wk[i-1];
                end
            end
        end

        // Feed-forward addition in its own cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                digest[STATE_W-1-WORD_W*i -: WORD_W] <= '0;
            end else if (feed) begin
                digest[STATE_W-1-WORD_W*i -: WORD_W] <= wk[i] + init[i];
            end
        end
    end

    // R5: word A of the result is working A plus captured A
    a_r5_feed_word_a: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> (digest[STATE_W-1 -: WORD_W] == $past(wk[0] + init[0])));

    // R5: working words are frozen during the feed cycle
    a_r5_frozen_in_feed: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && !step && !load) |=> $stable(wk[7]));
endmodule

// File: rtl/sha256_compress_unit.sv
module sha256_compress_unit
    import sha_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] chain_in,
    input  logic [BLOCK_W-1:0] block_in,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] digest
);
    ctl_state_e        state, state_nx;
    logic [RND_W-1:0]  rnd;
    logic              launch, step, feed, last_rnd;
    word_t             w_cur, k_cur;

    assign launch   = (state == S_IDLE) && start;
    assign step     = (state == S_ROUND);
    assign feed     = (state == S_FEED);
    assign last_rnd = (rnd == RND_W'(N_ROUNDS - 1));
    assign k_cur    = round_const(rnd);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start)    state_nx = S_ROUND;  // LAUNCH
            S_ROUND: if (last_rnd) state_nx = S_FEED;   // ROUNDS_DONE
            S_FEED:                state_nx = S_IDLE;   // FINISH
            default:               state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd  <= '0;
            done <= 1'b0;
        end else begin
            done <= feed;
            if (launch) begin
                rnd <= '0;
            end else if (step && !last_rnd) begin
                rnd <= rnd + 1'b1;
            end
        end
    end

    assign busy = (state != S_IDLE);

    sha_msg_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .shift    (step),
        .block_in (block_in),
        .w_cur    (w_cur)
    );

    sha_round_path u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .step     (step),
        .feed     (feed),
        .chain_in (chain_in),
        .k_cur    (k_cur),
        .w_cur    (w_cur),
        .digest   (digest)
    );

    // R2: a launch starts round 0
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && rnd == '0));

    // R2: rounds advance by one, leaving only after the last one
    a_r2_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((state == S_ROUND && rnd == $past(rnd) + 1'b1) ||
                  (state == S_FEED && $past(rnd) == RND_W'(N_ROUNDS - 1))));

    // R6: start while busy does not restart the round count
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start && !last_rnd) |=> (rnd != '0));

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: digest only moves with done
    a_r7_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(digest));

    // R8: busy is low while done is high
    a_r8_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sha256_compress_unit_tb_top.sv
`timescale 1ns/1ps
module sha256_compress_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] chain_in = '0;
    logic [511:0] block_in = '0;
    logic         busy, done;
    logic [255:0] digest;

    int checks = 0;
    int errors = 0;

    localparam logic [255:0] IV =
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [511:0] ABC_BLK = {32'h61626380, 416'h0, 64'h18};
    localparam logic [255:0] ABC_HASH =
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;

    localparam logic [2047:0] KREF = {
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    sha256_compress_unit dut_i (
        .clk (clk), .rst_n (rst_n), .start (start),
        .chain_in (chain_in), .block_in (block_in),
        .busy (busy), .done (done), .digest (digest)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_compress(input logic [255:0] h, input logic [511:0] m);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) v[i] = h[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KREF[(63-t)*32 +: 32] + w[t];
            t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) ref_compress[255-32*i -: 32] = v[i] + h[255-32*i -: 32];
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one job; a second start (with other operands) is injected at
    // sample index inj_at when inj_at > 0. Called at a falling edge.
    task automatic run_job(input logic [255:0] hc, input logic [511:0] mb, input int inj_at,
                           input string tag);
        int lat;
        logic [255:0] exp, held;
        exp = ref_compress(hc, mb);
        chain_in = hc; block_in = mb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (lat == 1) check(busy == 1'b1, "R8 busy after launch", {255'b0, busy}, 256'd1);
            if (inj_at > 0 && lat == inj_at) begin
                start = 1'b1; chain_in = ~hc; block_in = ~mb;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(lat == 65, {"R2 latency ", tag}, 256'(lat), 256'd65);
        check(digest == exp, {"R3 R4 R5 R6 digest ", tag}, digest, exp);
        check(busy == 1'b0, "R8 busy low with done", {255'b0, busy}, 256'd0);
        held = digest;
        @(negedge clk);
        check(done == 1'b0, "R7 single pulse", {255'b0, done}, 256'd0);
        check(busy == 1'b0, "R6 no restart after job", {255'b0, busy}, 256'd0);
        repeat (3) @(negedge clk);
        check(digest == held, "R7 digest holds", digest, held);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] rh;
        logic [511:0] rm;
        void'($urandom(32'h5a17c0de));
        repeat (3) @(negedge clk);
        // R1 reset values
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {254'b0, busy, done}, 256'd0);
        check(digest == '0, "R1 reset digest", digest, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(digest == '0 && !busy, "R1 after reset", digest, 256'd0);

        // R3 known vector
        run_job(IV, ABC_BLK, 0, "abc");
        check(digest == ABC_HASH, "R3 abc standard digest", digest, ABC_HASH);

        // corner patterns
        run_job('0, '0, 0, "zeros");
        run_job('1, '1, 64, "ones inject-in-feed R6");
        run_job(IV, ABC_BLK, 2, "inject-early R6");

        // random jobs
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 8; i++) rh[255-32*i -: 32] = $urandom;
            for (int i = 0; i < 16; i++) rm[511-32*i -: 32] = $urandom;
            run_job(rh, rm, (j % 2 == 1) ? int'($urandom_range(64, 2)) : 0, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule